// File: doc/BRIEF.md
# Flag-Producing Accumulator ALU

This block is the combinational arithmetic and logic stage of a small accumulator machine. Each cycle the sequencer presents an operation code, a register operand, a memory operand and the current status flags. The block returns a data result, a strobe that says whether the result should be written back, the updated flags, and a write-enable bit for each flag. Flags that an operation does not own come out equal to their incoming values, so the surrounding status register can simply take `flags_out` on every instruction.

Arithmetic is plain binary. The carry flag carries into addition. In subtraction it acts as an inverted borrow, so a set carry means that no borrow is taken. Compare and bit test only update flags, and they leave the result strobe low. The data width is a parameter with a default of 8. Decimal correction, register storage, sequencing and memory access belong to other blocks.

Top module: `flag_alu`

## Requirements
- R1: Op code 0 (add) returns the low WIDTH bits of opnd_a + opnd_m + C with res_we high. Carry becomes the bit above the sum, and all four flags are written.
- R2: Op code 1 (subtract) returns opnd_a - opnd_m - (1 - C) with res_we high. Carry is set when no borrow occurs and cleared when one does. All four flags are written.
- R3: For add and subtract, overflow is set exactly when the true signed result does not fit in WIDTH signed bits.
- R4: Op codes 2, 3 and 4 return AND, OR and XOR of the two operands with res_we high. Only zero (result is 0) and negative (result MSB) are written.
- R5: Op code 5 shifts opnd_a left, filling bit 0 with 0 and moving the old MSB into carry. Op code 6 shifts right, filling the MSB with 0 and moving the old bit 0 into carry. Zero and negative follow the result.
- R6: Op code 7 rotates opnd_a left, with the old carry entering bit 0 and the old MSB leaving to carry. Op code 8 rotates right, with the old carry entering the MSB and the old bit 0 leaving to carry. Zero and negative follow the result.
- R7: Op code 9 (compare) writes carry = (opnd_a >= opnd_m, unsigned), zero = (opnd_a == opnd_m) and negative = MSB of opnd_a - opnd_m. res_we is low and result reads 0.
- R8: Op code 10 (bit test) writes zero = ((opnd_a & opnd_m) == 0), negative = opnd_m MSB and overflow = opnd_m bit MSB-1. res_we is low and result reads 0.
- R9: Op codes 11 and 12 return opnd_a + 1 and opnd_a - 1, wrapping modulo 2^WIDTH. Only zero and negative are written.
- R10: flag_we and flags_in/flags_out use bit 0 = carry, bit 1 = zero, bit 2 = overflow, bit 3 = negative. flag_we is 1111 for add and subtract, 1010 for logic ops, increment and decrement, 1011 for shifts, rotates and compare, and 1110 for bit test. Every flag whose flag_we bit is 0 equals its flags_in bit.
- R11: Op codes 13 to 15 write nothing: flag_we is 0000, res_we is low, result is 0 and flags_out equals flags_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opnd_a | input | WIDTH | Accumulator or index register operand |
| opnd_m | input | WIDTH | Memory operand |
| flags_in | input | 4 | Current flags {N,V,Z,C} |
| result | output | WIDTH | Data result, 0 when res_we is low |
| res_we | output | 1 | Result is to be written back |
| flags_out | output | 4 | Updated flags {N,V,Z,C} |
| flag_we | output | 4 | Per-flag write mask {N,V,Z,C} |

## Verification
The bench builds two copies of the block. One copy has WIDTH=4 and is swept over every op code, every pair of operands and all sixteen incoming flag patterns. At that width every carry-out, signed-overflow edge and wrap of increment and decrement is reached, and the pass-through of unowned flags is seen under every flag pattern. The other copy has the default WIDTH=8. Every op code and every register operand is applied against the memory operands at the sign and boundary corners (0, 1, 0x7F, 0x80, 0xFF), with carry both clear and set. Together these confirm that the overflow and bit-test source positions follow the width.

// File: rtl/flag_alu_pkg.sv
// Package: operation codes, flag bit positions and the per-operation flag
// write mask shared by the ALU and its checker.
package flag_alu_pkg;

    typedef logic [3:0] op_code_t;

    localparam op_code_t OP_ADD = 4'd0;
    localparam op_code_t OP_SUB = 4'd1;
    localparam op_code_t OP_AND = 4'd2;
    localparam op_code_t OP_OR  = 4'd3;
    localparam op_code_t OP_XOR = 4'd4;
    localparam op_code_t OP_SHL = 4'd5;
    localparam op_code_t OP_SHR = 4'd6;
    localparam op_code_t OP_ROL = 4'd7;
    localparam op_code_t OP_ROR = 4'd8;
    localparam op_code_t OP_CMP = 4'd9;
    localparam op_code_t OP_BIT = 4'd10;
    localparam op_code_t OP_INC = 4'd11;
    localparam op_code_t OP_DEC = 4'd12;

    localparam int NUM_FLAGS = 4;
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_V = 2;
    localparam int FL_N = 3;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    // Flags owned by each operation ({N,V,Z,C}); unknown codes own none.
    function automatic flag_vec_t owned_flags(op_code_t op);
        case (op)
            OP_ADD, OP_SUB:                 return 4'b1111;
            OP_AND, OP_OR, OP_XOR:          return 4'b1010;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: return 4'b1011;
            OP_CMP:                         return 4'b1011;
            OP_BIT:                         return 4'b1110;
            OP_INC, OP_DEC:                 return 4'b1010;
            default:                        return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/flag_alu_addsub.sv
// Module: flag_alu_addsub
// Ripple-free binary adder: x + y + cin, with carry-out and signed overflow.
// Assumes the caller pre-inverts y for subtraction and compare.
module flag_alu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide;

    // Full-width sum including the carry bit above the MSB.
    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    end

    assign sum  = wide[MSB:0];
    assign cout = wide[WIDTH];
    // Signed overflow: equal operand signs that differ from the sum sign.
    assign ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/flag_alu_shift.sv
// Module: flag_alu_shift
// One-place shift/rotate network. dir_left picks direction, use_carry picks
// whether the vacated bit takes the incoming carry (rotate) or 0 (shift).
module flag_alu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] din,
    input  logic             cin,
    input  logic             dir_left,
    input  logic             use_carry,
    output logic [WIDTH-1:0] dout,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    logic fill_bit;

    assign fill_bit = use_carry & cin;

    // Per-bit source selection for both directions.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_lsb
            assign from_low = fill_bit;
        end else begin : g_mid_lo
            assign from_low = din[i-1];
        end
        if (i == MSB) begin : g_msb
            assign from_high = fill_bit;
        end else begin : g_mid_hi
            assign from_high = din[i+1];
        end
        assign dout[i] = dir_left ? from_low : from_high;
    end

    // The bit pushed out of the word goes to carry.
    assign cout = dir_left ? din[MSB] : din[0];
endmodule

// File: rtl/flag_alu_logic.sv
// Module: flag_alu_logic
// Bitwise unit: sel 0 = AND, 1 = OR, 2 = XOR, 3 = AND (used by bit test).
module flag_alu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] y
);
    // Select the bitwise function.
    always_comb begin
        case (sel)
            2'd1:    y = a | b;
            2'd2:    y = a ^ b;
            default: y = a & b;
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
// Module: flag_alu (top)
// Combinational ALU for an accumulator machine. Decodes op_sel, steers the
// operands into the adder, shifter or logic unit, forms new flags, and merges
// them with flags_in under a per-flag write mask. Assumes WIDTH >= 2 and
// binary arithmetic only.
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_m,
    input  logic [3:0]       flags_in,
    output logic [WIDTH-1:0] result,
    output logic             res_we,
    output logic [3:0]       flags_out,
    output logic [3:0]       flag_we
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] as_y;
    logic             as_cin;
    logic [WIDTH-1:0] as_sum;
    logic             as_cout;
    logic             as_ovf;
    logic             sh_left;
    logic             sh_rot;
    logic [WIDTH-1:0] sh_out;
    logic             sh_cout;
    logic [1:0]       lg_sel;
    logic [WIDTH-1:0] lg_out;
    logic [WIDTH-1:0] raw_res;
    logic             raw_we;
    logic             nf_c;
    logic             nf_v;
    logic [WIDTH-1:0] nz_src;
    logic             nf_n;
    flag_vec_t        new_flags;
    flag_vec_t        mask;

    // Adder operand steering: add, inverted-borrow subtract, compare, +1, -1.
    always_comb begin
        as_y   = opnd_m;
        as_cin = flags_in[FL_C];
        case (op_sel)
            OP_SUB: as_y = ~opnd_m;
            OP_CMP: begin
                as_y   = ~opnd_m;
                as_cin = 1'b1;
            end
            OP_INC: begin
                as_y   = '0;
                as_cin = 1'b1;
            end
            OP_DEC: begin
                as_y   = '1;
                as_cin = 1'b0;
            end
            default: ;
        endcase
    end

    // Shifter control from the op code.
    always_comb begin
        sh_left = (op_sel == OP_SHL) || (op_sel == OP_ROL);
        sh_rot  = (op_sel == OP_ROL) || (op_sel == OP_ROR);
    end

    // Logic unit function select.
    always_comb begin
        case (op_sel)
            OP_OR:   lg_sel = 2'd1;
            OP_XOR:  lg_sel = 2'd2;
            OP_BIT:  lg_sel = 2'd3;
            default: lg_sel = 2'd0;
        endcase
    end

    flag_alu_addsub #(.WIDTH(WIDTH)) addsub_i (
        .x    (opnd_a),
        .y    (as_y),
        .cin  (as_cin),
        .sum  (as_sum),
        .cout (as_cout),
        .ovf  (as_ovf)
    );

    flag_alu_shift #(.WIDTH(WIDTH)) shift_i (
        .din       (opnd_a),
        .cin       (flags_in[FL_C]),
        .dir_left  (sh_left),
        .use_carry (sh_rot),
        .dout      (sh_out),
        .cout      (sh_cout)
    );

    flag_alu_logic #(.WIDTH(WIDTH)) logic_i (
        .a   (opnd_a),
        .b   (opnd_m),
        .sel (lg_sel),
        .y   (lg_out)
    );

    // Result select, write strobe, and carry/overflow candidates per op.
    always_comb begin
        raw_res = '0;
        raw_we  = 1'b0;
        nf_c    = flags_in[FL_C];
        nf_v    = flags_in[FL_V];
        nz_src  = '0;
        case (op_sel)
            OP_ADD, OP_SUB: begin
                raw_res = as_sum;
                raw_we  = 1'b1;
                nf_c    = as_cout;
                nf_v    = as_ovf;
                nz_src  = as_sum;
            end
            OP_AND, OP_OR, OP_XOR: begin
                raw_res = lg_out;
                raw_we  = 1'b1;
                nz_src  = lg_out;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                raw_res = sh_out;
                raw_we  = 1'b1;
                nf_c    = sh_cout;
                nz_src  = sh_out;
            end
            OP_CMP: begin
                nf_c   = as_cout;
                nz_src = as_sum;
            end
            OP_BIT: begin
                nf_v   = opnd_m[MSB-1];
                nz_src = lg_out;
            end
            OP_INC, OP_DEC: begin
                raw_res = as_sum;
                raw_we  = 1'b1;
                nz_src  = as_sum;
            end
            default: ;
        endcase
    end

    // Negative comes from the memory operand for bit test, else the source.
    always_comb begin
        nf_n = (op_sel == OP_BIT) ? opnd_m[MSB] : nz_src[MSB];
    end

    // Gather the candidate flag vector and the ownership mask.
    always_comb begin
        new_flags       = '0;
        new_flags[FL_C] = nf_c;
        new_flags[FL_Z] = (nz_src == '0);
        new_flags[FL_V] = nf_v;
        new_flags[FL_N] = nf_n;
        mask            = owned_flags(op_sel);
    end

    // Per-flag merge: owned flags take the new value, the rest pass through.
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_merge
        assign flags_out[f] = mask[f] ? new_flags[f] : flags_in[f];
    end

    assign flag_we = mask;
    assign res_we  = raw_we;
    assign result  = raw_we ? raw_res : '0;
endmodule

// File: rtl/flag_alu_chk.sv
// Module: flag_alu_chk
// Property checker for flag_alu, bound to every instance below.
module flag_alu_chk
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_m,
    input logic [3:0]       flags_in,
    input logic [WIDTH-1:0] result,
    input logic             res_we,
    input logic [3:0]       flags_out,
    input logic [3:0]       flag_we
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] add_ref;
    logic           is_logic;

    // Reference sum and op class used by the properties.
    always_comb begin
        add_ref  = {1'b0, opnd_a} + {1'b0, opnd_m} + {{WIDTH{1'b0}}, flags_in[FL_C]};
        is_logic = (op_sel == OP_AND) || (op_sel == OP_OR) || (op_sel == OP_XOR);
    end

    // Immediate checks on the settled combinational outputs.
    always_comb begin
        p_add_sum_r1: assert (op_sel != OP_ADD || {flags_out[FL_C], result} == add_ref)
            else $error("add sum/carry mismatch");
        p_logic_no_carry_r4: assert (!is_logic || (!flag_we[FL_C] && !flag_we[FL_V]))
            else $error("logic op touched carry or overflow");
        p_cmp_no_result_r7: assert (op_sel != OP_CMP || (!res_we && result == '0))
            else $error("compare produced a result");
        p_cmp_carry_r7: assert (op_sel != OP_CMP || flags_out[FL_C] == (opnd_a >= opnd_m))
            else $error("compare carry wrong");
        p_bit_no_result_r8: assert (op_sel != OP_BIT || (!res_we && result == '0))
            else $error("bit test produced a result");
        p_bit_sign_r8: assert (op_sel != OP_BIT || flags_out[FL_N] == opnd_m[MSB])
            else $error("bit test negative wrong");
        p_undef_quiet_r11: assert (op_sel <= OP_DEC || (flag_we == 4'b0000 && !res_we))
            else $error("unassigned op wrote something");
        for (int f = 0; f < NUM_FLAGS; f++) begin
            p_hold_unowned_r10: assert (flag_we[f] || flags_out[f] == flags_in[f])
                else $error("unowned flag %0d changed", f);
        end
    end
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_m    (opnd_m),
    .flags_in  (flags_in),
    .result    (result),
    .res_we    (res_we),
    .flags_out (flags_out),
    .flag_we   (flag_we)
);

// File: tb/flag_alu_tb_top.sv
// Bench: exhaustive sweep of a 4-bit copy plus a corner sweep of an 8-bit
// copy, against an arithmetic model written from the requirements.
module flag_alu_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;

    logic [3:0] op4, f4, fo4, fwe4;
    logic [3:0] a4, m4, r4;
    logic       we4;
    logic [3:0] op8, f8, fo8, fwe8;
    logic [7:0] a8, m8, r8;
    logic       we8;

    flag_alu #(.WIDTH(4)) dut_i (
        .op_sel(op4), .opnd_a(a4), .opnd_m(m4), .flags_in(f4),
        .result(r4), .res_we(we4), .flags_out(fo4), .flag_we(fwe4)
    );

    flag_alu #(.WIDTH(8)) dut8_i (
        .op_sel(op8), .opnd_a(a8), .opnd_m(m8), .flags_in(f8),
        .result(r8), .res_we(we8), .flags_out(fo8), .flag_we(fwe8)
    );

    function automatic string op_tag(int op);
        case (op)
            0:        return "R1";
            1:        return "R2";
            2, 3, 4:  return "R4";
            5, 6:     return "R5";
            7, 8:     return "R6";
            9:        return "R7";
            10:       return "R8";
            11, 12:   return "R9";
            default:  return "R11";
        endcase
    endfunction

    function automatic int signed_of(int v, int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    // Expected behaviour per the requirements.
    task automatic model(input int w, input int op, input int a, input int m, input int fin,
                         output int res, output int we, output int fout, output int msk,
                         output int vexp);
        int mk, c, nc, nz, nv, nn, s, sr, lim;
        mk = (1 << w) - 1;
        c  = fin & 1;
        nc = 0; nv = 0; res = 0; we = 1; msk = 0; vexp = 0;
        lim = 1 << (w - 1);
        case (op)
            0: begin
                s = a + m + c; res = s & mk; nc = (s >> w) & 1;
                sr = signed_of(a, w) + signed_of(m, w) + c;
                nv = (sr >= lim || sr < -lim) ? 1 : 0; msk = 15;
            end
            1: begin
                s = a - m - (1 - c); res = s & mk; nc = (s >= 0) ? 1 : 0;
                sr = signed_of(a, w) - signed_of(m, w) - (1 - c);
                nv = (sr >= lim || sr < -lim) ? 1 : 0; msk = 15;
            end
            2: begin res = a & m; msk = 10; end
            3: begin res = a | m; msk = 10; end
            4: begin res = a ^ m; msk = 10; end
            5: begin res = (a << 1) & mk; nc = (a >> (w - 1)) & 1; msk = 11; end
            6: begin res = a >> 1; nc = a & 1; msk = 11; end
            7: begin res = ((a << 1) | c) & mk; nc = (a >> (w - 1)) & 1; msk = 11; end
            8: begin res = (a >> 1) | (c << (w - 1)); nc = a & 1; msk = 11; end
            9: begin res = (a - m) & mk; nc = (a >= m) ? 1 : 0; we = 0; msk = 11; end
            10: begin res = a & m; nv = (m >> (w - 2)) & 1; we = 0; msk = 14; end
            11: begin res = (a + 1) & mk; msk = 10; end
            12: begin res = (a - 1) & mk; msk = 10; end
            default: begin res = 0; we = 0; msk = 0; end
        endcase
        nz = (res == 0) ? 1 : 0;
        nn = (res >> (w - 1)) & 1;
        if (op == 9) nz = (a == m) ? 1 : 0;
        if (op == 10) nn = (m >> (w - 1)) & 1;
        if (we == 0) res = 0;
        vexp = nv;
        fout = 0;
        fout |= ((msk & 1) != 0 ? nc : (fin & 1));
        fout |= ((msk & 2) != 0 ? nz : ((fin >> 1) & 1)) << 1;
        fout |= ((msk & 4) != 0 ? nv : ((fin >> 2) & 1)) << 2;
        fout |= ((msk & 8) != 0 ? nn : ((fin >> 3) & 1)) << 3;
    endtask

    task automatic check(input string tag, input string what, input int w, input int op,
                         input int a, input int m, input int fin, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s w=%0d op=%0d a=%0h m=%0h fin=%0h actual=%0h expected=%0h",
                     tag, what, w, op, a, m, fin, act, exp);
        end
    endtask

    task automatic compare(input int w, input int op, input int a, input int m, input int fin,
                           input int ares, input int awe, input int afo, input int afwe);
        int eres, ewe, efo, emsk, ev;
        string t;
        model(w, op, a, m, fin, eres, ewe, efo, emsk, ev);
        t = op_tag(op);
        check(t, "result", w, op, a, m, fin, ares, eres);
        check(t, "res_we", w, op, a, m, fin, awe, ewe);
        check(t, "flags_out", w, op, a, m, fin, afo, efo);
        check("R10", "flag_we", w, op, a, m, fin, afwe, emsk);
        if (op <= 1) check("R3", "overflow", w, op, a, m, fin, (afo >> 2) & 1, ev);
    endtask

    // Watchdog: an overrun counts as a failed check.
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 180000) begin
                total++;
                bad++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int mlist[5];
        mlist[0] = 0; mlist[1] = 1; mlist[2] = 8'h7F; mlist[3] = 8'h80; mlist[4] = 8'hFF;
        op4 = '0; a4 = '0; m4 = '0; f4 = '0;
        op8 = '0; a8 = '0; m8 = '0; f8 = '0;
        // 4-bit copy: every op, operand pair and flag pattern (R1..R11).
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int m = 0; m < 16; m++) begin
                    for (int f = 0; f < 16; f++) begin
                        @(posedge clk);
                        op4 = 4'(op); a4 = 4'(a); m4 = 4'(m); f4 = 4'(f);
                        @(negedge clk);
                        compare(4, op, a, m, f, int'(r4), int'(we4), int'(fo4), int'(fwe4));
                    end
                end
            end
        end
        // 8-bit copy: every op and register operand against corner memory values.
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int mi = 0; mi < 5; mi++) begin
                    for (int fi = 0; fi < 4; fi++) begin
                        int f;
                        f = (fi < 2) ? fi : (fi + 12);
                        @(posedge clk);
                        op8 = 4'(op); a8 = 8'(a); m8 = 8'(mlist[mi]); f8 = 4'(f);
                        @(negedge clk);
                        compare(8, op, a, mlist[mi], f, int'(r8), int'(we8), int'(fo8), int'(fwe8));
                    end
                end
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule